// File: doc/BRIEF.md
# Runtime-Programmable Sum-of-Products Logic Array

This block is a soft logic array whose function is set at run time. It takes N data inputs, forms K product terms and drives M outputs. Each product term can connect to the true literal, the complemented literal, or neither literal of every input. Each output ORs any chosen subset of the product terms. A per-output polarity bit then either passes that sum unchanged or inverts it. Because of the polarity bit, one shared set of product terms can produce either a function or its complement.

The connection map lives in registers and is written through a small configuration port. One write carries three things:
- a selector that names the target: a product-term row, an output column, or the polarity register;
- an address that picks the row or column;
- a data word.

Once the map is loaded, the outputs follow the data inputs combinationally, with no clock in the path.

Top module: `prog_logic_array`

## Requirements
- R1: While `rst_n` is low, and after it is released, every connection and polarity bit is cleared. `out_vec` is 0 for every input value until the array is programmed. Asserting the reset again after programming returns the array to this state.
- R2: A product-term row holds a 2-bit field for each input i, at `cfg_data[2i+1:2i]`. Field 01 requires input i to be 1, field 10 requires input i to be 0, and field 00 ignores input i.
- R3: A product term whose fields are all 00 is always 1. Any field of 11 holds that product term at 0 for every input value.
- R4: Output m is the OR of the product terms whose bits are set in its OR column, where bit k of `cfg_data[K-1:0]` selects term k. If the column is empty, the sum is 0 before the polarity stage.
- R5: Polarity bit m is taken from `cfg_data[m]`; `cfg_addr` has no effect on this write. A 1 inverts the OR sum of output m, and a 0 passes it unchanged.
- R6: `cfg_sel` encodes the target: 0 selects a product-term row (`cfg_addr` is the term index), 1 selects an OR column (`cfg_addr` is the output index), and 2 selects the polarity register. A write with `cfg_we` high takes effect at the next rising clock edge. With `cfg_we` low, the stored map does not change.
- R7: A row or column write whose address has no matching term or output is ignored. A write with `cfg_sel` equal to 3 is also ignored.
- R8: With the products AB', AC, BC and A'BC', and with F1 = AB'+AC+A'BC' (true) and F2 = (AC+BC)' (inverted), the outputs match both equations for all input values. A is input 2 and C is input 0, F1 is output 0, and F2 is output 1.
- R9: With the products AB, AC, BC and A'B'C', and with F1 = (AB+AC+BC)' (inverted) and F2 = AB+AC+A'B'C' (true), the outputs match both equations for all input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 = term row, 1 = output column, 2 = polarity |
| cfg_addr | input | max(1, clog2(max(K,M))) | Term or output index |
| cfg_data | input | max(2N,K,M) | Row, column or polarity word |
| in_vec | input | N | Data inputs |
| out_vec | output | M | Array outputs |

## Verification
The conditions hardest to reach from the ports are the ones that two correct configurations never produce: a conflicting 11 field, an all-ignore term, an empty OR column under inversion, and writes that must be dropped. The stimulus builds each of these on purpose with single-row writes. It then sweeps all eight input values through each case. Write timing is checked by sampling the outputs after the write data is driven but before the clock edge that stores it, and again after that edge.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    SEL_TERM = 2'd0,
    SEL_COL  = 2'd1,
    SEL_POL  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_target_e;

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 2,
  parameter int DW     = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_sel,
  input  logic [AW-1:0]                     cfg_addr,
  input  logic [DW-1:0]                     cfg_data,
  output logic [N_TERM-1:0][2*N_IN-1:0]     term_map,
  output logic [N_OUT-1:0][N_TERM-1:0]      col_map,
  output logic [N_OUT-1:0]                  pol_map
);

  localparam int FW = 2 * N_IN;

  cfg_target_e                      target;
  logic                             wr_term, wr_col, wr_pol;
  logic [N_TERM-1:0][FW-1:0]        term_q, term_nx;
  logic [N_OUT-1:0][N_TERM-1:0]     col_q, col_nx;
  logic [N_OUT-1:0]                 pol_q, pol_nx;

  assign target  = cfg_target_e'(cfg_sel);
  assign wr_term = cfg_we && (target == SEL_TERM);
  assign wr_col  = cfg_we && (target == SEL_COL);
  assign wr_pol  = cfg_we && (target == SEL_POL);

  // next-state: address decode per row and column
  always_comb begin
    term_nx = term_q;
    col_nx  = col_q;
    pol_nx  = pol_q;
    for (int k = 0; k < N_TERM; k++) begin
      if (wr_term && (cfg_addr == AW'(k))) term_nx[k] = cfg_data[FW-1:0];
    end
    for (int m = 0; m < N_OUT; m++) begin
      if (wr_col && (cfg_addr == AW'(m))) col_nx[m] = cfg_data[N_TERM-1:0];
    end
    if (wr_pol) pol_nx = cfg_data[N_OUT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      col_q  <= '0;
      pol_q  <= '0;
    end else if (cfg_we) begin
      term_q <= term_nx;
      col_q  <= col_nx;
      pol_q  <= pol_nx;
    end
  end

  assign term_map = term_q;
  assign col_map  = col_q;
  assign pol_map  = pol_q;

  // R6: no write strobe, no change in the stored map
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(term_q) && $stable(col_q) && $stable(pol_q)));

  // R7: the unused selector code alters nothing
  a_r7_unused_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> ($stable(term_q) && $stable(col_q) && $stable(pol_q)));

  // R7: a column write leaves the term rows alone
  a_r7_col_write_spares_terms: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1) |=> $stable(term_q));

  // R5: a polarity write lands its data bits
  a_r5_pol_written: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2) |=> (pol_q == $past(cfg_data[N_OUT-1:0])));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               in_vec,
  input  logic [N_TERM-1:0][2*N_IN-1:0] term_map,
  output logic [N_TERM-1:0]             term_val
);

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    logic [N_IN-1:0] clash;
    logic [N_IN-1:0] free;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      logic use_true, use_comp;
      assign use_true = term_map[k][2*i];
      assign use_comp = term_map[k][2*i+1];
      // a connected literal must be 1; both connected gives a constant 0
      assign lit_ok[i] = (!use_true || in_vec[i]) && (!use_comp || !in_vec[i]);
      assign clash[i]  = (term_map[k][2*i+1 -: 2] == 2'b11);
      assign free[i]   = (term_map[k][2*i+1 -: 2] == 2'b00);
    end

    assign term_val[k] = &lit_ok;

    // R3: a field of 11 pins the product term low
    a_r3_clash_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (|clash) |-> !term_val[k]);

    // R3: a row of ignored inputs is a constant 1
    a_r3_all_free_is_one: assert property (@(posedge clk) disable iff (!rst_n)
      (&free) |-> term_val[k]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_TERM-1:0]             term_val,
  input  logic [N_OUT-1:0][N_TERM-1:0]  col_map,
  input  logic [N_OUT-1:0]              pol_map,
  output logic [N_OUT-1:0]              out_vec
);

  for (genvar m = 0; m < N_OUT; m++) begin : g_out
    logic sum;
    assign sum        = |(col_map[m] & term_val);
    assign out_vec[m] = sum ^ pol_map[m];

    // R4: an empty column shows only the polarity bit
    a_r4_empty_column: assert property (@(posedge clk) disable iff (!rst_n)
      (col_map[m] == '0) |-> (out_vec[m] == pol_map[m]));

    // R4 and R5: one live selected term drives the sum high before polarity
    a_r5_live_term_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      ((col_map[m] & term_val) != '0) |-> (out_vec[m] == !pol_map[m]));
  end

endmodule

// File: rtl/prog_logic_array.sv
module prog_logic_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int IDX_MAX = (N_TERM > N_OUT) ? N_TERM : N_OUT,
  localparam int AW      = (IDX_MAX > 1) ? $clog2(IDX_MAX) : 1,
  localparam int DW_A    = (2 * N_IN > N_TERM) ? 2 * N_IN : N_TERM,
  localparam int DW      = (DW_A > N_OUT) ? DW_A : N_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_data,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  logic [N_TERM-1:0][2*N_IN-1:0] term_map;
  logic [N_OUT-1:0][N_TERM-1:0]  col_map;
  logic [N_OUT-1:0]              pol_map;
  logic [N_TERM-1:0]             term_val;

  pla_cfg_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW), .DW(DW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .term_map(term_map), .col_map(col_map), .pol_map(pol_map)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk(clk), .rst_n(rst_n), .in_vec(in_vec),
    .term_map(term_map), .term_val(term_val)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst_n(rst_n), .term_val(term_val),
    .col_map(col_map), .pol_map(pol_map), .out_vec(out_vec)
  );

  // R1: a cleared array yields all-zero outputs
  a_r1_cleared_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_map == '0 && col_map == '0) |-> (out_vec == '0));

endmodule

// File: tb/prog_logic_array_bench.sv
module prog_logic_array_bench;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [1:0] cfg_addr;
  logic [5:0] cfg_data;
  logic [2:0] in_vec;
  logic [1:0] out_vec;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  prog_logic_array u_prog_logic_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_vec(in_vec), .out_vec(out_vec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, in_vec, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] addr, input logic [5:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // sweep all inputs against a fixed expected pair
  task automatic sweep_const(input string req, input logic [1:0] exp);
    for (int v = 0; v < 8; v++) begin
      in_vec = 3'(v);
      #1;
      chk(req, out_vec, exp);
    end
  endtask

  task automatic load_cfg1;
    wr(2'd0, 2'd0, 6'b01_10_00);  // AB'
    wr(2'd0, 2'd1, 6'b01_00_01);  // AC
    wr(2'd0, 2'd2, 6'b00_01_01);  // BC
    wr(2'd0, 2'd3, 6'b10_01_10);  // A'BC'
    wr(2'd1, 2'd0, 6'b00_1011);
    wr(2'd1, 2'd1, 6'b00_0110);
    wr(2'd2, 2'd0, 6'b000010);
  endtask

  task automatic load_cfg2;
    wr(2'd0, 2'd0, 6'b01_01_00);  // AB
    wr(2'd0, 2'd1, 6'b01_00_01);  // AC
    wr(2'd0, 2'd2, 6'b00_01_01);  // BC
    wr(2'd0, 2'd3, 6'b10_10_10);  // A'B'C'
    wr(2'd1, 2'd0, 6'b00_0111);
    wr(2'd1, 2'd1, 6'b00_1011);
    wr(2'd2, 2'd0, 6'b000001);
  endtask

  function automatic logic [1:0] gold1(input logic [2:0] v);
    logic a, b, c;
    a = v[2]; b = v[1]; c = v[0];
    return {~((a & c) | (b & c)), (a & ~b) | (a & c) | (~a & b & ~c)};
  endfunction

  function automatic logic [1:0] gold2(input logic [2:0] v);
    logic a, b, c;
    a = v[2]; b = v[1]; c = v[0];
    return {(a & b) | (a & c) | (~a & ~b & ~c), ~((a & b) | (a & c) | (b & c))};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_addr = '0; cfg_data = '0; in_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cleared after reset
    sweep_const("R1 reset", 2'b00);

    // R8: first reference configuration, all input values
    load_cfg1();
    for (int v = 0; v < 8; v++) begin
      in_vec = 3'(v); #1;
      chk("R8 cfg1", out_vec, gold1(3'(v)));
    end

    // R7: out-of-range column address and unused selector leave cfg1 intact
    wr(2'd1, 2'd2, 6'b00_1111);
    wr(2'd3, 2'd0, 6'b111111);
    for (int v = 0; v < 8; v++) begin
      in_vec = 3'(v); #1;
      chk("R7 ignored write", out_vec, gold1(3'(v)));
    end

    // R6: strobe low, data driven, no change
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd2; cfg_data = 6'b000001;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      in_vec = 3'(v); #1;
      chk("R6 no strobe", out_vec, gold1(3'(v)));
    end

    // R6: write lands at the edge, not before
    in_vec = 3'b000;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_addr = 2'd3; cfg_data = 6'b000001;
    #1;
    chk("R6 before edge", out_vec, gold1(3'b000));
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R6 after edge R5", out_vec, gold1(3'b000) ^ 2'b11);

    // R1: reset again clears the map
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sweep_const("R1 re-reset", 2'b00);

    // R4 and R5: empty columns show polarity only
    wr(2'd2, 2'd0, 6'b000011);
    sweep_const("R4 empty column R5", 2'b11);
    wr(2'd2, 2'd0, 6'b000000);

    // R3: all-ignore term is constant 1
    wr(2'd1, 2'd0, 6'b00_0001);
    sweep_const("R3 all free", 2'b01);

    // R3: a conflicting field holds the term at 0
    wr(2'd0, 2'd0, 6'b11_00_00);
    sweep_const("R3 clash", 2'b00);

    // R2: each encoding on input 1 alone; R5 inverts it on output 1
    wr(2'd0, 2'd0, 6'b00_01_00);
    wr(2'd1, 2'd1, 6'b00_0001);
    wr(2'd2, 2'd0, 6'b000010);
    for (int v = 0; v < 8; v++) begin
      in_vec = 3'(v); #1;
      chk("R2 true literal", out_vec, {~v[1], v[1]});
    end
    wr(2'd0, 2'd0, 6'b00_10_00);
    for (int v = 0; v < 8; v++) begin
      in_vec = 3'(v); #1;
      chk("R2 comp literal", out_vec, {v[1], ~v[1]});
    end

    // R9: second reference configuration
    load_cfg2();
    for (int v = 0; v < 8; v++) begin
      in_vec = 3'(v); #1;
      chk("R9 cfg2", out_vec, gold2(3'(v)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule